// File: doc/BRIEF.md
# Auxiliary Lookup RAM Controller

This block sits beside a small processor core and owns a second 512-word by 32-bit lookup RAM. The core reaches the RAM in three ways: a dedicated read instruction and a dedicated write instruction, which both take their word address from the already-resolved source operand; instruction fetch, whenever the upper bit of the 10-bit program counter selects the upper half of the code space; and a neighbour port, through which a paired core may write words while shared mode is on. The RAM is never offered to the core as a direct operand.

Because the instruction's address is only known when the instruction starts, the read is issued in the first clock. The returned word is captured into a holding register in the second clock and drives the result path in the third clock. A write is done in its first clock and the instruction finishes in its second. A small sequencer drives a busy signal that stalls the core for every cycle but the last one. It uses four states. `ST_IDLE` waits for a start. The transition *start-read* goes from `ST_IDLE` to `ST_RD_CAP`, and *start-write* goes from `ST_IDLE` to `ST_WR_FIN`. *capture* goes from `ST_RD_CAP` to `ST_RD_OUT`. *read-finish* goes from `ST_RD_OUT` to `ST_IDLE`, and *write-finish* goes from `ST_WR_FIN` to `ST_IDLE`.

Instruction fetch uses a separate read path, so code runs from the RAM at full speed. When the counter is in the lower half, the fetched word comes from the core's register RAM and is passed through this block unchanged.

Top module: `lkram_ctrl`

## Requirements
- R1: An instruction started with `op_start`=1 and `op_kind`=0 (read) in cycle 1 yields `rd_valid`=1, `op_done`=1 and `rd_data` equal to the RAM word at `s_addr` in cycle 3. `rd_data` holds that word afterwards.
- R2: An instruction started with `op_kind`=1 (write) stores `wr_data` at `s_addr` at the end of cycle 1. `op_done`=1 in cycle 2 with `rd_valid`=0.
- R3: `busy` is 1 in cycles 1 and 2 of a read and in cycle 1 of a write. It is 0 in the final cycle of each instruction and while idle.
- R4: `op_start` is ignored while an instruction is in progress (read cycles 2 and 3, write cycle 2).
- R5: When `pc[9]`=1, `fetch_word` in the next cycle equals the RAM word at `pc[8:0]`, and `fetch_from_lut`=1. A new fetch is accepted every cycle.
- R6: When `pc[9]`=0, `fetch_word` in the next cycle equals `reg_fetch_word`, and `fetch_from_lut`=0.
- R7: With `share_en`=1, a clock with `nb_we`=1 stores `nb_wdata` at `nb_addr`.
- R8: With `share_en`=0, `nb_we` has no effect on the RAM.
- R9: If a local write and a neighbour write hit the same address in the same clock, the local data is kept.
- R10: A read (instruction or fetch) issued in the same clock as a write to its address returns the old word.
- R11: Reset returns the sequencer to idle (`busy`, `op_done` and `rd_valid` are 0) and clears `rd_data` to 0. RAM contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Instruction start strobe, taken only when idle |
| op_kind | input | 1 | 0 = read, 1 = write |
| s_addr | input | 9 | Word address from the resolved source operand |
| wr_data | input | 32 | Data for a write instruction |
| busy | output | 1 | Stall request to the core pipeline |
| op_done | output | 1 | Final cycle of an instruction |
| rd_valid | output | 1 | `rd_data` is the result of a read in this cycle |
| rd_data | output | 32 | Holding register feeding the result mux |
| pc | input | 10 | Program counter of the fetch |
| reg_fetch_word | input | 32 | Word fetched from register RAM, one cycle after `pc` |
| fetch_word | output | 32 | Selected instruction word |
| fetch_from_lut | output | 1 | Fetched word came from the lookup RAM |
| share_en | input | 1 | Shared mode enable for the neighbour port |
| nb_we | input | 1 | Neighbour write enable |
| nb_addr | input | 9 | Neighbour write address |
| nb_wdata | input | 32 | Neighbour write data |

## Verification
The bound checker watches the sequencer's timing on every cycle. It checks that a read result always follows exactly two busy cycles, that a write's completion follows one busy cycle, that completion lasts a single cycle, and that the fetch source flag follows the counter's upper bit. Only the directed scenarios can show the data itself. That covers the values returned by reads and fetches, the effect of neighbour writes with shared mode on and off, write priority on a collision, old-data return on a same-clock read and write, starts dropped while busy, and RAM contents surviving reset.

// File: rtl/lkram_pkg.sv
package lkram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_CAP = 2'd1,
        ST_RD_OUT = 2'd2,
        ST_WR_FIN = 2'd3
    } seq_state_t;

    localparam logic OP_READ  = 1'b0;
    localparam logic OP_WRITE = 1'b1;
endpackage

// File: rtl/lkram_store.sv
// Word store with a local port (write or read), a fetch read port and a
// neighbour write port. Reads are registered and see pre-write contents.
module lkram_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_we,
    input  logic              loc_re,
    input  logic [AW-1:0]     loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_q,
    input  logic              nb_we,
    input  logic [AW-1:0]     nb_addr,
    input  logic [DATA_W-1:0] nb_wdata,
    input  logic [AW-1:0]     f_addr,
    output logic [DATA_W-1:0] f_q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Local write is placed last so it overrides a same-address neighbour write.
    always_ff @(posedge clk) begin
        if (nb_we)
            mem[nb_addr] <= nb_wdata;
        if (loc_we)
            mem[loc_addr] <= loc_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_q <= '0;
            f_q   <= '0;
        end else begin
            if (loc_re)
                loc_q <= mem[loc_addr];
            f_q <= mem[f_addr];
        end
    end
endmodule

// File: rtl/lkram_seq.sv
// Per-instruction sequencer: read = 3 clocks, write = 2 clocks.
module lkram_seq
    import lkram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_kind,
    output logic busy,
    output logic op_done,
    output logic rd_valid,
    output logic issue_rd,
    output logic issue_wr,
    output logic cap_en
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start)
                    state_d = (op_kind == OP_WRITE) ? ST_WR_FIN : ST_RD_CAP;
            end
            ST_RD_CAP: state_d = ST_RD_OUT;
            ST_RD_OUT: state_d = ST_IDLE;
            ST_WR_FIN: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        busy     = 1'b0;
        op_done  = 1'b0;
        rd_valid = 1'b0;
        issue_rd = 1'b0;
        issue_wr = 1'b0;
        cap_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = op_start;
                issue_rd = op_start && (op_kind == OP_READ);
                issue_wr = op_start && (op_kind == OP_WRITE);
            end
            ST_RD_CAP: begin
                busy   = 1'b1;
                cap_en = 1'b1;
            end
            ST_RD_OUT: begin
                op_done  = 1'b1;
                rd_valid = 1'b1;
            end
            ST_WR_FIN: op_done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lkram_fetch.sv
// Selects the fetched word by the counter's upper bit, one cycle late.
module lkram_fetch #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_upper,
    input  logic [DATA_W-1:0] lut_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] fetch_word,
    output logic              fetch_from_lut
);
    logic sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else
            sel_q <= pc_upper;
    end

    assign fetch_word     = sel_q ? lut_word : reg_word;
    assign fetch_from_lut = sel_q;
endmodule

// File: rtl/lkram_ctrl.sv
module lkram_ctrl #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int PC_W  = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_kind,
    input  logic [AW-1:0]     s_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              op_done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] reg_fetch_word,
    output logic [DATA_W-1:0] fetch_word,
    output logic              fetch_from_lut,
    input  logic              share_en,
    input  logic              nb_we,
    input  logic [AW-1:0]     nb_addr,
    input  logic [DATA_W-1:0] nb_wdata
);
    logic              issue_rd, issue_wr, cap_en;
    logic [DATA_W-1:0] loc_q, f_q, hold_q;

    lkram_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .busy     (busy),
        .op_done  (op_done),
        .rd_valid (rd_valid),
        .issue_rd (issue_rd),
        .issue_wr (issue_wr),
        .cap_en   (cap_en)
    );

    lkram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_we    (issue_wr),
        .loc_re    (issue_rd),
        .loc_addr  (s_addr),
        .loc_wdata (wr_data),
        .loc_q     (loc_q),
        .nb_we     (nb_we && share_en),
        .nb_addr   (nb_addr),
        .nb_wdata  (nb_wdata),
        .f_addr    (pc[AW-1:0]),
        .f_q       (f_q)
    );

    lkram_fetch #(.DATA_W(DATA_W)) fetch_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pc_upper       (pc[PC_W-1]),
        .lut_word       (f_q),
        .reg_word       (reg_fetch_word),
        .fetch_word     (fetch_word),
        .fetch_from_lut (fetch_from_lut)
    );

    // Holding register: capture in cycle 2, drive the result path in cycle 3.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (cap_en)
            hold_q <= loc_q;
    end

    assign rd_data = hold_q;
endmodule

// File: rtl/lkram_chk.sv
module lkram_chk #(
    parameter int PC_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            op_done,
    input logic            rd_valid,
    input logic            fetch_from_lut,
    input logic [PC_W-1:0] pc
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    p_valid_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> op_done);

    p_valid_after_two_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && rd_valid) |-> ($past(busy) && $past(busy, 2)));

    p_write_after_one_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && op_done && !rd_valid) |-> ($past(busy) && !$past(op_done)));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    p_busy_max_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && busy && $past(busy)) |=> !busy);

    p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !busy);

    p_fetch_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> (fetch_from_lut == $past(pc[PC_W-1])));
endmodule

bind lkram_ctrl lkram_chk #(.PC_W(PC_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .op_done        (op_done),
    .rd_valid       (rd_valid),
    .fetch_from_lut (fetch_from_lut),
    .pc             (pc)
);

// File: tb/lkram_ctrl_tb.sv
`timescale 1ns/1ps
module lkram_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic        op_kind = 1'b0;
    logic [8:0]  s_addr = '0;
    logic [31:0] wr_data = '0;
    logic        busy, op_done, rd_valid, fetch_from_lut;
    logic [31:0] rd_data, fetch_word;
    logic [9:0]  pc = '0;
    logic [31:0] reg_fetch_word = '0;
    logic        share_en = 1'b0;
    logic        nb_we = 1'b0;
    logic [8:0]  nb_addr = '0;
    logic [31:0] nb_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    lkram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .s_addr(s_addr), .wr_data(wr_data), .busy(busy), .op_done(op_done),
        .rd_valid(rd_valid), .rd_data(rd_data), .pc(pc),
        .reg_fetch_word(reg_fetch_word), .fetch_word(fetch_word),
        .fetch_from_lut(fetch_from_lut), .share_en(share_en), .nb_we(nb_we),
        .nb_addr(nb_addr), .nb_wdata(nb_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write instruction with timing checks (R2, R3).
    task automatic do_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        op_start = 1'b1; op_kind = 1'b1; s_addr = a; wr_data = d;
        #1 chk(busy == 1'b1, "R3 write cycle1 busy", 32'(busy), 32'd1);
        @(negedge clk);
        op_start = 1'b0;
        #1 chk(op_done && !busy && !rd_valid, "R2 write done cycle2",
               {29'd0, op_done, busy, rd_valid}, 32'd4);
    endtask

    // Read instruction with timing and data checks (R1, R3).
    task automatic do_read(input logic [8:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        op_start = 1'b1; op_kind = 1'b0; s_addr = a;
        #1 chk(busy == 1'b1, "R3 read cycle1 busy", 32'(busy), 32'd1);
        @(negedge clk);
        op_start = 1'b0;
        #1 chk(busy && !op_done && !rd_valid, "R3 read cycle2 busy",
               {29'd0, busy, op_done, rd_valid}, 32'd4);
        @(negedge clk);
        #1 chk(rd_valid && op_done && !busy, "R1 read cycle3 flags",
               {29'd0, rd_valid, op_done, busy}, 32'd6);
        chk(rd_data == exp, req, rd_data, exp);
        @(negedge clk);
        #1 chk(!rd_valid && !busy && rd_data == exp, "R1 read idle after",
               rd_data, exp);
    endtask

    task automatic t_basic_rw();
        do_write(9'd3, 32'hA5A5_0003);
        do_write(9'd511, 32'h1234_01FF);
        do_read(9'd3, 32'hA5A5_0003, "R1 R2 read back addr 3");
        do_read(9'd511, 32'h1234_01FF, "R1 R2 read back addr 511");
    endtask

    task automatic t_start_ignored();
        do_write(9'd20, 32'h0000_0020);
        do_write(9'd21, 32'h0000_0021);
        // Read 20; hold a write start to 21 through the read's cycles 2 and 3.
        @(negedge clk);
        op_start = 1'b1; op_kind = 1'b0; s_addr = 9'd20;
        @(negedge clk);
        op_kind = 1'b1; s_addr = 9'd21; wr_data = 32'hDEAD_0021;
        #1 chk(busy == 1'b1, "R4 busy in cycle2", 32'(busy), 32'd1);
        @(negedge clk);
        #1 chk(rd_valid && rd_data == 32'h0000_0020, "R4 read unaffected",
               rd_data, 32'h0000_0020);
        @(negedge clk);
        op_start = 1'b0;
        do_read(9'd21, 32'h0000_0021, "R4 ignored start during read");
        // Start held during a write's cycle 2.
        @(negedge clk);
        op_start = 1'b1; op_kind = 1'b1; s_addr = 9'd22; wr_data = 32'h0000_0022;
        @(negedge clk);
        s_addr = 9'd23; wr_data = 32'hBEEF_0023;
        #1 chk(op_done && !busy, "R4 write cycle2", {30'd0, op_done, busy}, 32'd2);
        @(negedge clk);
        op_start = 1'b0;
        do_write(9'd23, 32'h0000_0023);
        do_read(9'd22, 32'h0000_0022, "R4 write data kept");
    endtask

    task automatic t_fetch();
        do_write(9'd5, 32'hC0DE_0005);
        do_write(9'd6, 32'hC0DE_0006);
        @(negedge clk);
        pc = 10'h205; reg_fetch_word = 32'hFFFF_0000;
        @(negedge clk);
        pc = 10'h206;
        #1 chk(fetch_from_lut && fetch_word == 32'hC0DE_0005, "R5 fetch upper 205",
               fetch_word, 32'hC0DE_0005);
        @(negedge clk);
        pc = 10'h005; reg_fetch_word = 32'h5555_AAAA;
        #1 chk(fetch_from_lut && fetch_word == 32'hC0DE_0006, "R5 fetch upper 206",
               fetch_word, 32'hC0DE_0006);
        @(negedge clk);
        #1 chk(!fetch_from_lut && fetch_word == 32'h5555_AAAA, "R6 fetch lower 005",
               fetch_word, 32'h5555_AAAA);
        reg_fetch_word = 32'h0BAD_F00D;
        #1 chk(fetch_word == 32'h0BAD_F00D, "R6 register word passes",
               fetch_word, 32'h0BAD_F00D);
    endtask

    task automatic t_neighbour();
        do_write(9'd40, 32'h0000_0040);
        // Shared mode off: neighbour write dropped.
        @(negedge clk);
        share_en = 1'b0; nb_we = 1'b1; nb_addr = 9'd40; nb_wdata = 32'hBAD0_0040;
        @(negedge clk);
        nb_we = 1'b0;
        do_read(9'd40, 32'h0000_0040, "R8 neighbour ignored when off");
        // Shared mode on: neighbour write lands.
        @(negedge clk);
        share_en = 1'b1; nb_we = 1'b1; nb_addr = 9'd41; nb_wdata = 32'h0AB0_0041;
        @(negedge clk);
        nb_we = 1'b0;
        do_read(9'd41, 32'h0AB0_0041, "R7 neighbour write when on");
        // Collision: local write wins.
        @(negedge clk);
        op_start = 1'b1; op_kind = 1'b1; s_addr = 9'd42; wr_data = 32'h10CA_0042;
        nb_we = 1'b1; nb_addr = 9'd42; nb_wdata = 32'h0E1B_0042;
        @(negedge clk);
        op_start = 1'b0; nb_we = 1'b0;
        do_read(9'd42, 32'h10CA_0042, "R9 local wins collision");
        share_en = 1'b0;
    endtask

    task automatic t_read_during_write();
        do_write(9'd50, 32'h0000_0050);
        do_write(9'd7, 32'h0000_0007);
        // Read instruction issued while neighbour writes the same word.
        share_en = 1'b1;
        @(negedge clk);
        op_start = 1'b1; op_kind = 1'b0; s_addr = 9'd50;
        nb_we = 1'b1; nb_addr = 9'd50; nb_wdata = 32'h0000_5050;
        @(negedge clk);
        op_start = 1'b0; nb_we = 1'b0;
        @(negedge clk);
        #1 chk(rd_valid && rd_data == 32'h0000_0050, "R10 read sees old word",
               rd_data, 32'h0000_0050);
        share_en = 1'b0;
        do_read(9'd50, 32'h0000_5050, "R10 new word after");
        // Fetch in the clock of a local write to the same word.
        @(negedge clk);
        pc = 10'h207;
        op_start = 1'b1; op_kind = 1'b1; s_addr = 9'd7; wr_data = 32'h7777_0007;
        @(negedge clk);
        op_start = 1'b0;
        #1 chk(fetch_word == 32'h0000_0007, "R10 fetch sees old word",
               fetch_word, 32'h0000_0007);
        @(negedge clk);
        #1 chk(fetch_word == 32'h7777_0007, "R10 fetch sees new word",
               fetch_word, 32'h7777_0007);
        pc = 10'h000;
    endtask

    task automatic t_reset();
        do_write(9'd60, 32'h0000_0060);
        do_read(9'd60, 32'h0000_0060, "R11 preload");
        @(negedge clk);
        op_start = 1'b1; op_kind = 1'b0; s_addr = 9'd60;
        @(negedge clk);
        op_start = 1'b0;
        rst_n = 1'b0;
        #1 chk(!busy && !op_done && !rd_valid, "R11 sequencer idle in reset",
               {29'd0, busy, op_done, rd_valid}, 32'd0);
        chk(rd_data == 32'd0, "R11 holding register cleared", rd_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        do_read(9'd60, 32'h0000_0060, "R11 RAM kept over reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(!busy && !op_done && !rd_valid && rd_data == 0, "R11 reset state",
               rd_data, 32'd0);
        rst_n = 1'b1;
        t_basic_rw();
        t_start_ignored();
        t_fetch();
        t_neighbour();
        t_read_during_write();
        t_reset();
        repeat (2) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule